// File: doc/BRIEF.md
# Data Watchpoint and Cycle Counter

This block watches the load/store traffic of a processor core and raises a debug halt request when an access hits one of a small set of programmable comparators. Each comparator holds a watch address, an address mask and a function code. The mask widens an exact match into an aligned region. The function code selects whether stores alone, or both loads and stores, can trigger the comparator. It also carries a free-running cycle counter for profiling code regions with two register reads.

Configuration goes through a plain word-indexed register port with one-cycle write strobes and combinational read data. Index 0 is the control word: the enable for the counter at bit 0 and the implemented comparator count in bits [31:28]. Index 1 is the counter. Comparator i owns indices 4+4i (watch address), 5+4i (mask, low bits) and 6+4i (function). In the function word, bits [3:0] hold the code and bit 24 holds a sticky matched flag. The observed bus is never stalled. The access strobe has no ready, so no back-pressure exists, and every strobed access is evaluated in the cycle it appears. A master trace enable input gates both the counter and all comparators.

Top module: `data_watch_unit`

## Requirements
- R1: After reset the counter reads 0, no comparator match or halt request is raised, all comparator registers read 0, and the control word reads the comparator count in bits [31:28] with bit 0 clear.
- R2: With mask value M the comparator compares address bits [31:M] only; M = 0 is an exact match.
- R3: Function code 6 matches only store accesses (acc_write = 1).
- R4: Function code 7 matches loads and stores. Code 0 and every other code leave the comparator disabled.
- R5: While control bit 0 and trace_en are both 1, the counter increases by one per clock and wraps from 0xFFFFFFFF to 0.
- R6: A write to the counter index loads the written value and takes priority over the increment in that cycle.
- R7: While trace_en is 0 no comparator matches and the counter holds its value.
- R8: An access that satisfies a comparator in clock cycle T sets that comparator's cmp_match bit and halt_req during cycle T+1 only. It also sets bit 24 of that comparator's function word.
- R9: A read of a function word returns the flag and clears it. When a new match lands in the same cycle as the read, the flag stays set.
- R10: The comparator count field in the control word is read-only; writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trace_en | input | 1 | Master trace enable gating counter and comparators |
| acc_valid | input | 1 | Data bus access strobe |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_addr | input | 32 | Access address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears flag on function reads) |
| reg_addr | input | 6 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| cmp_match | output | 4 | Per-comparator match pulse |
| halt_req | output | 1 | Debug halt request pulse |
| cyc_count | output | 32 | Cycle counter value |

## Verification
The assertions cover the cycle-level rules on every clock. A match pulse must follow a strobed access made while trace_en was set. A write-only comparator must never fire on a load. The counter must step by exactly one while running and hold while trace_en is low. The matched flag may rise only together with a match pulse. The bench scenarios cover what depends on stored configuration and on arithmetic: the mask widths, every function code, counter wrap and load priority, read-to-clear with a concurrent match, and the read-only count field.

// File: rtl/dwu_pkg.sv
package dwu_pkg;
  localparam int FN_W        = 4;
  localparam logic [FN_W-1:0] FN_OFF = 4'h0;
  localparam logic [FN_W-1:0] FN_WR  = 4'h6;
  localparam logic [FN_W-1:0] FN_RW  = 4'h7;

  localparam int REG_CTRL     = 0;
  localparam int REG_CNT      = 1;
  localparam int REG_CMP_BASE = 4;
  localparam int CMP_STRIDE   = 4;
  localparam int OFS_ADDR     = 0;
  localparam int OFS_MASK     = 1;
  localparam int OFS_FUNC     = 2;

  localparam int CTRL_EN_BIT  = 0;
  localparam int NCMP_W       = 4;
  localparam int FLAG_BIT     = 24;
endpackage

// File: rtl/dwu_cycle_counter.sv
module dwu_cycle_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= load_val;
    else if (run)  count <= count + W'(1);
  end
endmodule

// File: rtl/dwu_comparator.sv
module dwu_comparator import dwu_pkg::*; #(
  parameter int AW = 32,
  parameter int MW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trace_en,
  input  logic            acc_valid,
  input  logic            acc_write,
  input  logic [AW-1:0]   acc_addr,
  input  logic            wr_addr,
  input  logic            wr_mask,
  input  logic            wr_func,
  input  logic [AW-1:0]   wdata_addr,
  input  logic [MW-1:0]   wdata_mask,
  input  logic [FN_W-1:0] wdata_func,
  input  logic            rd_clr,
  output logic [AW-1:0]   cfg_addr,
  output logic [MW-1:0]   cfg_mask,
  output logic [FN_W-1:0] cfg_func,
  output logic            flag,
  output logic            hit
);
  logic [AW-1:0] care;
  logic          addr_eq;
  logic          fn_ok;
  logic          hit_d;

  always_comb begin
    care    = {AW{1'b1}} << cfg_mask;
    addr_eq = ((acc_addr ^ cfg_addr) & care) == '0;
    unique case (cfg_func)
      FN_WR:   fn_ok = acc_write;
      FN_RW:   fn_ok = 1'b1;
      default: fn_ok = 1'b0;
    endcase
    hit_d = trace_en && acc_valid && fn_ok && addr_eq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_addr <= '0;
      cfg_mask <= '0;
      cfg_func <= FN_OFF;
    end else begin
      if (wr_addr) cfg_addr <= wdata_addr;
      if (wr_mask) cfg_mask <= wdata_mask;
      if (wr_func) cfg_func <= wdata_func;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit  <= 1'b0;
      flag <= 1'b0;
    end else begin
      hit <= hit_d;
      if (hit_d)       flag <= 1'b1;
      else if (rd_clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/data_watch_unit.sv
module data_watch_unit import dwu_pkg::*; #(
  parameter int NUM_CMP = 4,
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int REG_AW  = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trace_en,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic [AW-1:0]      acc_addr,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  output logic [DW-1:0]      reg_rdata,
  output logic [NUM_CMP-1:0] cmp_match,
  output logic               halt_req,
  output logic [DW-1:0]      cyc_count
);
  localparam int MW = $clog2(AW);

  logic                    cnt_en;
  logic                    cnt_load;
  logic [AW-1:0]           cfg_addr [NUM_CMP];
  logic [MW-1:0]           cfg_mask [NUM_CMP];
  logic [FN_W-1:0]         cfg_func [NUM_CMP];
  logic [NUM_CMP-1:0]      flag_vec;
  logic [NUM_CMP*FN_W-1:0] fn_flat;

  assign cnt_load = reg_wr && (reg_addr == REG_AW'(REG_CNT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_en <= 1'b0;
    else if (reg_wr && (reg_addr == REG_AW'(REG_CTRL))) cnt_en <= reg_wdata[CTRL_EN_BIT];
  end

  dwu_cycle_counter #(.W(DW)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (cnt_en && trace_en),
    .load     (cnt_load),
    .load_val (reg_wdata),
    .count    (cyc_count)
  );

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    localparam int BASE = REG_CMP_BASE + CMP_STRIDE * g;
    logic sel_addr, sel_mask, sel_func;
    assign sel_addr = reg_addr == REG_AW'(BASE + OFS_ADDR);
    assign sel_mask = reg_addr == REG_AW'(BASE + OFS_MASK);
    assign sel_func = reg_addr == REG_AW'(BASE + OFS_FUNC);

    dwu_comparator #(.AW(AW), .MW(MW)) u_cmp (
      .clk        (clk),
      .rst_n      (rst_n),
      .trace_en   (trace_en),
      .acc_valid  (acc_valid),
      .acc_write  (acc_write),
      .acc_addr   (acc_addr),
      .wr_addr    (reg_wr && sel_addr),
      .wr_mask    (reg_wr && sel_mask),
      .wr_func    (reg_wr && sel_func),
      .wdata_addr (reg_wdata[AW-1:0]),
      .wdata_mask (reg_wdata[MW-1:0]),
      .wdata_func (reg_wdata[FN_W-1:0]),
      .rd_clr     (reg_rd && sel_func),
      .cfg_addr   (cfg_addr[g]),
      .cfg_mask   (cfg_mask[g]),
      .cfg_func   (cfg_func[g]),
      .flag       (flag_vec[g]),
      .hit        (cmp_match[g])
    );
    assign fn_flat[g*FN_W +: FN_W] = cfg_func[g];
  end

  assign halt_req = |cmp_match;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == REG_AW'(REG_CTRL)) begin
      reg_rdata[DW-1 -: NCMP_W] = NCMP_W'(NUM_CMP);
      reg_rdata[CTRL_EN_BIT]    = cnt_en;
    end
    if (reg_addr == REG_AW'(REG_CNT)) reg_rdata = cyc_count;
    for (int i = 0; i < NUM_CMP; i++) begin
      if (reg_addr == REG_AW'(REG_CMP_BASE + CMP_STRIDE*i + OFS_ADDR))
        reg_rdata = DW'(cfg_addr[i]);
      if (reg_addr == REG_AW'(REG_CMP_BASE + CMP_STRIDE*i + OFS_MASK))
        reg_rdata = DW'(cfg_mask[i]);
      if (reg_addr == REG_AW'(REG_CMP_BASE + CMP_STRIDE*i + OFS_FUNC)) begin
        reg_rdata[FN_W-1:0] = cfg_func[i];
        reg_rdata[FLAG_BIT] = flag_vec[i];
      end
    end
  end
endmodule

// File: rtl/dwu_checker.sv
module dwu_checker import dwu_pkg::*; #(
  parameter int NUM_CMP = 4,
  parameter int DW      = 32,
  parameter int REG_AW  = 6
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    trace_en,
  input logic                    acc_valid,
  input logic                    acc_write,
  input logic                    reg_wr,
  input logic [REG_AW-1:0]       reg_addr,
  input logic [DW-1:0]           cyc_count,
  input logic [NUM_CMP-1:0]      cmp_match,
  input logic                    cnt_en,
  input logic [NUM_CMP-1:0]      flag_vec,
  input logic [NUM_CMP*FN_W-1:0] fn_flat
);
  logic cnt_wr;
  assign cnt_wr = reg_wr && (reg_addr == REG_AW'(REG_CNT));

  AST_MATCH_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmp_match) |-> ($past(acc_valid) && $past(trace_en))); // R7

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_en && cnt_en && !cnt_wr) |=> (cyc_count == DW'($past(cyc_count) + DW'(1)))); // R5

  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!trace_en && !cnt_wr) |=> $stable(cyc_count)); // R7

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_chk
    AST_WR_ONLY_ON_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_match[g] && ($past(fn_flat[g*FN_W +: FN_W]) == FN_WR)) |-> $past(acc_write)); // R3

    AST_FLAG_FROM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_vec[g]) |-> cmp_match[g]); // R8
  end
endmodule

bind data_watch_unit dwu_checker #(
  .NUM_CMP (NUM_CMP),
  .DW      (DW),
  .REG_AW  (REG_AW)
) u_dwu_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .trace_en  (trace_en),
  .acc_valid (acc_valid),
  .acc_write (acc_write),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .cyc_count (cyc_count),
  .cmp_match (cmp_match),
  .cnt_en    (cnt_en),
  .flag_vec  (flag_vec),
  .fn_flat   (fn_flat)
);

// File: tb/data_watch_unit_bench.sv
module data_watch_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCMP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trace_en = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NCMP-1:0] cmp_match;
  logic        halt_req;
  logic [31:0] cyc_count;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  data_watch_unit u_data_watch_unit (
    .clk(clk), .rst_n(rst_n), .trace_en(trace_en),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cmp_match(cmp_match), .halt_req(halt_req), .cyc_count(cyc_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [5:0] idx(input int c, input int ofs);
    return 6'(4 + 4*c + ofs);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  // one access; returns match vector and halt seen in the following cycle
  task automatic access(input logic [31:0] a, input logic w,
                        output logic [NCMP-1:0] m, output logic h);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_write = w;
    @(posedge clk);
    #1 m = cmp_match; h = halt_req;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  initial begin
    logic [31:0] v, v2;
    logic [NCMP-1:0] m;
    logic h;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    #1;
    check(cyc_count == 0, "R1 counter", cyc_count, 0);
    check(cmp_match == 0 && !halt_req, "R1 no match", {27'b0, halt_req, cmp_match}, 0);
    rd(6'd0, v);
    check(v == 32'h4000_0000, "R1 ctrl", v, 32'h4000_0000);
    rd(idx(2, 2), v);
    check(v == 0, "R1 func reg", v, 0);
    trace_en = 1'b1;
    access(32'h0, 1'b1, m, h);
    check(m == 0 && !h, "R1 R4 disabled after reset", {27'b0, h, m}, 0);

    // R2: mask sweep per comparator, function 7
    for (int c = 0; c < NCMP; c++) begin
      logic [31:0] base;
      base = 32'h4000_0000 + 32'(c) * 32'h1000;
      wr(idx(c, 0), base);
      wr(idx(c, 2), 32'h7);
      for (int mk = 0; mk <= 6; mk++) begin
        wr(idx(c, 1), 32'(mk));
        for (int off = 0; off < 64; off++) begin
          logic [NCMP-1:0] exp;
          exp = '0;
          exp[c] = ((off >> mk) == 0);
          access(base ^ 32'(off), off[0], m, h);
          check(m == exp && h == (|exp), "R2 mask match", {27'b0, h, m}, {27'b0, |exp, exp});
        end
      end
      wr(idx(c, 2), 32'h0);
      wr(idx(c, 1), 32'h0);
    end

    // R3 R4: function code sweep on comparator 0
    wr(idx(0, 0), 32'h2000_0100);
    for (int f = 0; f < 16; f++) begin
      wr(idx(0, 2), 32'(f));
      for (int w = 0; w < 2; w++) begin
        logic e;
        e = (f == 7) || (f == 6 && w == 1);
        access(32'h2000_0100, w[0], m, h);
        check(m == {3'b0, e} && h == e, (f == 6) ? "R3 write-only code" : "R4 function code",
              {27'b0, h, m}, {27'b0, e, 3'b0, e});
      end
    end
    wr(idx(0, 2), 32'h0);
    rd(idx(0, 2), v);  // clear any flag

    // R8: single pulse, flag set
    wr(idx(1, 0), 32'h3000_0040);
    wr(idx(1, 1), 32'h0);
    wr(idx(1, 2), 32'h6);
    rd(idx(1, 2), v);
    access(32'h3000_0040, 1'b1, m, h);
    check(m == 4'b0010 && h, "R8 match pulse", {27'b0, h, m}, 32'h12);
    @(posedge clk); #1;
    check(cmp_match == 0 && !halt_req, "R8 pulse one cycle", {27'b0, halt_req, cmp_match}, 0);
    // R9: read returns flag then clears
    rd(idx(1, 2), v);
    check(v == 32'h0100_0006, "R8 R9 flag read", v, 32'h0100_0006);
    rd(idx(1, 2), v);
    check(v == 32'h0000_0006, "R9 flag cleared", v, 32'h0000_0006);
    // R9: match concurrent with read keeps flag
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = idx(1, 2);
    acc_valid = 1'b1; acc_addr = 32'h3000_0040; acc_write = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0; acc_valid = 1'b0;
    rd(idx(1, 2), v);
    check(v[24], "R9 set wins over clear", v, 32'h0100_0006);

    // R7: trace_en low blocks matches
    trace_en = 1'b0;
    access(32'h3000_0040, 1'b1, m, h);
    check(m == 0 && !h, "R7 no match without trace", {27'b0, h, m}, 0);
    trace_en = 1'b1;

    // R5: counting
    wr(6'd0, 32'h1);
    wr(6'd1, 32'h0);
    repeat (25) @(posedge clk);
    #1 check(cyc_count == 25, "R5 count", cyc_count, 25);
    wr(6'd1, 32'hFFFF_FFFE);
    repeat (3) @(posedge clk);
    #1 check(cyc_count == 1, "R5 wrap", cyc_count, 1);
    // R6: load has priority over increment
    wr(6'd1, 32'd100);
    check(cyc_count == 100, "R6 load priority", cyc_count, 100);
    rd(6'd1, v);
    check(v == 101, "R6 read counter", v, 101);
    // R7: trace off freezes counter
    @(negedge clk);
    trace_en = 1'b0;
    v = cyc_count;
    repeat (6) @(posedge clk);
    #1 check(cyc_count == v, "R7 counter holds", cyc_count, v);
    trace_en = 1'b1;
    // R5: enable bit clear holds counter
    wr(6'd0, 32'h0);
    v = cyc_count;
    repeat (5) @(posedge clk);
    #1 check(cyc_count == v, "R5 disabled holds", cyc_count, v);

    // R10: count field read-only
    wr(6'd0, 32'hFFFF_FFFF);
    rd(6'd0, v2);
    check(v2 == 32'h4000_0001, "R10 ctrl read-only field", v2, 32'h4000_0001);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule